// File: doc/BRIEF.md
# Dock handshake wrapper with flush tokens

This block sits between a compute unit and a switch fabric. It adapts the unit's input docks and output docks to a four-phase request/acknowledge/data handshake. Each input dock word is one bit wider than the unit's data word. The extra top bit marks a flush token, not a data value. The wrapper hides tokens from the unit by masking them out of the request the unit sees. It keeps one acknowledge register and one flush flag per input dock. The acknowledge that goes back to the fabric is the OR of those two.

Flushing is decided jointly across all input docks. The rule is evaluated only when every input dock is requesting and none has yet been acknowledged. If every dock presents a token, all docks are flagged, so all of them are acknowledged together. If only some docks present a token, the docks that hold ordinary data are flagged. Their data is drained until every dock lines up on a token. A flag stays set until that dock's request drops.

Output docks are simple. The unit asks to send, a request register raises the fabric request, and the fabric acknowledge clears it. The unit's word passes straight through to the fabric.

Top module: `dock_wrap`

## Requirements
- R1: While rst_n is low, and on the first cycle after it is released, every in_ack bit is 1 and every out_req bit is 0.
- R2: For input dock i, unit_in_valid[i] equals in_req[i] AND NOT token bit. The token bit is bit WORD_W of that dock's in_data slice. unit_in_word carries the low WORD_W bits of each dock's in_data unchanged.
- R3: in_ack[i] is the OR of dock i's acknowledge register and dock i's flush flag.
- R4: Dock i's acknowledge register is 0 from the cycle after any cycle in which in_req[i] is low. It becomes 1 in the cycle after a cycle in which unit_take[i] and unit_in_valid[i] are both high, and stays 1 while in_req[i] stays high.
- R5: Dock i's flush flag is 0 from the cycle after any cycle in which in_req[i] is low.
- R6: In a cycle where every in_req bit is 1, every acknowledge register is 0 and every token bit is 1, all flush flags are set. The next cycle shows in_ack all ones.
- R7: Under the same request and acknowledge condition, when some but not all token bits are 1, the flag is set on each dock whose token bit is 0. The flags of docks whose token bit is 1 keep their previous value.
- R8: When that condition does not hold, or no token bit is 1, no flush flag is set.
- R9: out_req[j] becomes 1 in the cycle after unit_out_send[j] is high while out_req[j] is 0. It becomes 0 in the cycle after out_ack[j] is high while out_req[j] is 1, and otherwise holds. out_data equals unit_out_word at all times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_req | input | N_IN | Raw request of each input dock |
| in_data | input | N_IN*(WORD_W+1) | Input dock words; bit WORD_W of each slice is the token bit |
| in_ack | output | N_IN | Acknowledge to the fabric for each input dock |
| unit_in_valid | output | N_IN | Request with tokens masked out, to the unit |
| unit_in_word | output | N_IN*WORD_W | Data part of each input dock word |
| unit_take | input | N_IN | Unit consumes the word on a valid dock |
| unit_out_send | input | N_OUT | Unit asks to send on an output dock |
| unit_out_word | input | N_OUT*WORD_W | Word the unit drives on each output dock |
| out_req | output | N_OUT | Request of each output dock to the fabric |
| out_data | output | N_OUT*WORD_W | Output dock words |
| out_ack | input | N_OUT | Fabric acknowledge of each output dock |

## Verification
A wrong acknowledge register or flush flag shows on in_ack in the very next cycle. Such a fault would either drop a word the unit never took, or hang the fabric by never acknowledging a token. The joint rule is exercised with all-token, partial-token and no-token patterns, entered after a request drop so that every acknowledge register starts at 0. A stuck output request register shows on out_req one cycle after the send or acknowledge that should have moved it.

// File: rtl/dock_wrap_pkg.sv
// Package: shared types for the dock handshake wrapper.
// Assumes nothing beyond the IEEE 1800-2017 language.
package dock_wrap_pkg;

    // Outcome of the joint flush evaluation across all input docks.
    typedef enum logic [1:0] {
        JOIN_NONE    = 2'd0,  // condition unmet or no token present
        JOIN_ALL     = 2'd1,  // every dock holds a token
        JOIN_PARTIAL = 2'd2   // some docks hold a token
    } join_kind_t;

endpackage

// File: rtl/flush_join.sv
// Module: flush_join
// Combinational joint flush decision. It yields a per-dock set mask for the
// flush flags. Assumes ack_reg reflects the lanes' acknowledge registers.
module flush_join
    import dock_wrap_pkg::*;
#(
    parameter int N_IN = 3
) (
    input  logic [N_IN-1:0] raw_req,
    input  logic [N_IN-1:0] ack_reg,
    input  logic [N_IN-1:0] token,
    output logic [N_IN-1:0] set_mask
);

    join_kind_t kind;

    // Classify the current cycle against the joint rule.
    always_comb begin
        if (!(&raw_req) || (|ack_reg) || !(|token))
            kind = JOIN_NONE;
        else if (&token)
            kind = JOIN_ALL;
        else
            kind = JOIN_PARTIAL;
    end

    // Turn the classification into flag set enables.
    always_comb begin
        case (kind)
            JOIN_ALL:     set_mask = '1;
            JOIN_PARTIAL: set_mask = ~token;
            default:      set_mask = '0;
        endcase
    end

endmodule

// File: rtl/dock_in_lane.sv
// Module: dock_in_lane
// One input dock: acknowledge register, flush flag, token masking and the
// merged acknowledge. Assumes a four-phase handshake from the fabric.
module dock_in_lane (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_req,
    input  logic token,
    input  logic take,
    input  logic set_flag,
    output logic valid,
    output logic ack_reg,
    output logic ack_out
);

    logic flag_q;

    // Hide flush tokens from the unit.
    always_comb valid = raw_req & ~token;

    // Present either a real acknowledge or a forced flush acknowledge.
    always_comb ack_out = ack_reg | flag_q;

    // Acknowledge register: cleared by request drop, set by a unit take.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ack_reg <= 1'b1;
        else if (!raw_req)
            ack_reg <= 1'b0;
        else if (take && valid && !ack_reg)
            ack_reg <= 1'b1;
    end

    // Flush flag: cleared by request drop, set by the joint rule.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else if (!raw_req)
            flag_q <= 1'b0;
        else if (set_flag)
            flag_q <= 1'b1;
    end

    p_ack_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !raw_req |=> !ack_reg);
    p_flag_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !raw_req |=> !ack_out);
    p_ack_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_reg && raw_req) |=> ack_reg);

endmodule

// File: rtl/dock_out_lane.sv
// Module: dock_out_lane
// One output dock: request register raised by the unit, cleared by the
// fabric acknowledge. Data is not registered here.
module dock_out_lane (
    input  logic clk,
    input  logic rst_n,
    input  logic send,
    input  logic ack,
    output logic req
);

    // Request register with send set and acknowledge clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            req <= 1'b0;
        else if (req && ack)
            req <= 1'b0;
        else if (send && !req)
            req <= 1'b1;
    end

    p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !ack) |=> req);
    p_req_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!req && send) |=> req);

endmodule

// File: rtl/dock_wrap.sv
// Module: dock_wrap (top)
// Adapts a unit's input and output docks to the fabric handshake. It handles
// token masking, per-dock flush flags and the joint flush rule. Assumes each
// input slice is WORD_W+1 bits with the token in the top bit.
module dock_wrap #(
    parameter int N_IN   = 3,
    parameter int N_OUT  = 2,
    parameter int WORD_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_IN-1:0]         in_req,
    input  logic [N_IN*(WORD_W+1)-1:0] in_data,
    output logic [N_IN-1:0]         in_ack,
    output logic [N_IN-1:0]         unit_in_valid,
    output logic [N_IN*WORD_W-1:0]  unit_in_word,
    input  logic [N_IN-1:0]         unit_take,
    input  logic [N_OUT-1:0]        unit_out_send,
    input  logic [N_OUT*WORD_W-1:0] unit_out_word,
    output logic [N_OUT-1:0]        out_req,
    output logic [N_OUT*WORD_W-1:0] out_data,
    input  logic [N_OUT-1:0]        out_ack
);

    localparam int SLICE_W = WORD_W + 1;

    logic [N_IN-1:0] token;
    logic [N_IN-1:0] ack_reg_w;
    logic [N_IN-1:0] set_mask;

    flush_join #(.N_IN(N_IN)) join_i (
        .raw_req  (in_req),
        .ack_reg  (ack_reg_w),
        .token    (token),
        .set_mask (set_mask)
    );

    for (genvar i = 0; i < N_IN; i++) begin : g_in
        // Split each dock slice into token bit and data word.
        always_comb begin
            token[i] = in_data[i*SLICE_W + WORD_W];
            unit_in_word[i*WORD_W +: WORD_W] = in_data[i*SLICE_W +: WORD_W];
        end

        dock_in_lane lane_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .raw_req  (in_req[i]),
            .token    (token[i]),
            .take     (unit_take[i]),
            .set_flag (set_mask[i]),
            .valid    (unit_in_valid[i]),
            .ack_reg  (ack_reg_w[i]),
            .ack_out  (in_ack[i])
        );
    end

    for (genvar j = 0; j < N_OUT; j++) begin : g_out
        dock_out_lane lane_o (
            .clk   (clk),
            .rst_n (rst_n),
            .send  (unit_out_send[j]),
            .ack   (out_ack[j]),
            .req   (out_req[j])
        );
    end

    // Output words go to the fabric unmodified.
    always_comb out_data = unit_out_word;

    always_comb begin
        if (rst_n) begin
            p_mask_r2: assert ((unit_in_valid & token) == '0);
            p_merge_r3: assert ((ack_reg_w & ~in_ack) == '0);
        end
    end

    p_all_token_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((&in_req) && !(|ack_reg_w) && (&token)) |=> (&in_ack));
    p_partial_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((&in_req) && !(|ack_reg_w) && (|token) && !(&token))
        |=> ((in_ack & ~$past(token)) == ~$past(token)));

endmodule

// File: tb/dock_wrap_tb_top.sv
// Bench for dock_wrap: fixed-seed random stimulus plus directed flush cases,
// compared against a behavioural model built from the requirements.
module dock_wrap_tb_top;

    localparam int N_IN   = 3;
    localparam int N_OUT  = 2;
    localparam int WORD_W = 8;
    localparam int SLICE_W = WORD_W + 1;
    localparam int CLK_PERIOD = 10;

    logic                       clk = 1'b0;
    logic                       rst_n;
    logic [N_IN-1:0]            in_req;
    logic [N_IN*SLICE_W-1:0]    in_data;
    logic [N_IN-1:0]            in_ack;
    logic [N_IN-1:0]            unit_in_valid;
    logic [N_IN*WORD_W-1:0]     unit_in_word;
    logic [N_IN-1:0]            unit_take;
    logic [N_OUT-1:0]           unit_out_send;
    logic [N_OUT*WORD_W-1:0]    unit_out_word;
    logic [N_OUT-1:0]           out_req;
    logic [N_OUT*WORD_W-1:0]    out_data;
    logic [N_OUT-1:0]           out_ack;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [N_IN-1:0]  m_ack, m_flag;
    logic [N_OUT-1:0] m_oreq;

    always #(CLK_PERIOD/2) clk = ~clk;

    dock_wrap #(.N_IN(N_IN), .N_OUT(N_OUT), .WORD_W(WORD_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_req(in_req), .in_data(in_data),
        .in_ack(in_ack), .unit_in_valid(unit_in_valid),
        .unit_in_word(unit_in_word), .unit_take(unit_take),
        .unit_out_send(unit_out_send), .unit_out_word(unit_out_word),
        .out_req(out_req), .out_data(out_data), .out_ack(out_ack)
    );

    function automatic logic [N_IN-1:0] tokens_of(logic [N_IN*SLICE_W-1:0] d);
        logic [N_IN-1:0] t;
        for (int i = 0; i < N_IN; i++) t[i] = d[i*SLICE_W + WORD_W];
        return t;
    endfunction

    function automatic logic [N_IN*WORD_W-1:0] words_of(logic [N_IN*SLICE_W-1:0] d);
        logic [N_IN*WORD_W-1:0] w;
        for (int i = 0; i < N_IN; i++) w[i*WORD_W +: WORD_W] = d[i*SLICE_W +: WORD_W];
        return w;
    endfunction

    function automatic logic [N_IN-1:0] join_set(logic [N_IN-1:0] req,
                                                 logic [N_IN-1:0] ack,
                                                 logic [N_IN-1:0] tok);
        if (!(&req) || (|ack) || (tok == '0)) return '0;
        if (&tok) return '1;
        return ~tok;
    endfunction

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Check outputs for the current inputs, then advance the model over one edge.
    task automatic cycle();
        logic [N_IN-1:0] tok, n_ack, n_flag, setm;
        logic [N_OUT-1:0] n_oreq;
        #1;
        tok = tokens_of(in_data);
        check(32'(in_ack), 32'(m_ack | m_flag), "R3 in_ack");
        check(32'(unit_in_valid), 32'(in_req & ~tok), "R2 valid");
        check(32'(unit_in_word), 32'(words_of(in_data)), "R2 word");
        check(32'(out_req), 32'(m_oreq), "R9 out_req");
        check(32'(out_data), 32'(unit_out_word), "R9 out_data");
        setm = join_set(in_req, m_ack, tok);
        for (int i = 0; i < N_IN; i++) begin
            if (!rst_n) begin n_ack[i] = 1'b1; n_flag[i] = 1'b0; end
            else if (!in_req[i]) begin n_ack[i] = 1'b0; n_flag[i] = 1'b0; end
            else begin
                n_ack[i] = m_ack[i] | (unit_take[i] & ~tok[i]);
                n_flag[i] = m_flag[i] | setm[i];
            end
        end
        for (int j = 0; j < N_OUT; j++) begin
            if (!rst_n) n_oreq[j] = 1'b0;
            else if (m_oreq[j] && out_ack[j]) n_oreq[j] = 1'b0;
            else if (unit_out_send[j] && !m_oreq[j]) n_oreq[j] = 1'b1;
            else n_oreq[j] = m_oreq[j];
        end
        @(posedge clk);
        m_ack = n_ack; m_flag = n_flag; m_oreq = n_oreq;
        @(negedge clk);
    endtask

    function automatic logic [N_IN*SLICE_W-1:0] mk_data(logic [N_IN-1:0] tok);
        logic [N_IN*SLICE_W-1:0] d;
        for (int i = 0; i < N_IN; i++) begin
            d[i*SLICE_W +: WORD_W] = WORD_W'(8'h30 + i);
            d[i*SLICE_W + WORD_W] = tok[i];
        end
        return d;
    endfunction

    initial begin
        logic [N_IN-1:0] tk;
        void'($urandom(32'd4242));
        m_ack = '1; m_flag = '0; m_oreq = '0;
        rst_n = 1'b0; in_req = '0; in_data = '0; unit_take = '0;
        unit_out_send = '0; unit_out_word = '0; out_ack = '0;
        @(negedge clk);
        #1;
        check(32'(in_ack), 32'h7, "R1 reset in_ack");
        check(32'(out_req), 32'h0, "R1 reset out_req");
        cycle(); cycle();
        rst_n = 1'b1;
        #1;
        check(32'(in_ack), 32'h7, "R1 first cycle in_ack");
        cycle();
        check(32'(in_ack), 32'h0, "R4 ack cleared after idle request");

        // R6: all docks present a token after acks are clear.
        in_req = '1; in_data = mk_data(3'b111);
        cycle();
        check(32'(in_ack), 32'h7, "R6 all tokens flush all");
        in_req = '0; cycle();
        check(32'(in_ack), 32'h0, "R5 flags cleared by request drop");

        // R7: only dock 0 holds a token; docks 1 and 2 are drained.
        in_req = '1; in_data = mk_data(3'b001);
        cycle();
        check(32'(in_ack), 32'h6, "R7 partial tokens flag data docks");
        cycle();
        check(32'(in_ack), 32'h6, "R7 token dock stays unacknowledged");
        in_req = '0; cycle();

        // R8: no tokens, no take: nothing is acknowledged.
        in_req = '1; in_data = mk_data(3'b000);
        cycle();
        check(32'(in_ack), 32'h0, "R8 no tokens no flag");
        // R4: unit takes dock 1 only.
        unit_take = 3'b010; cycle(); unit_take = '0;
        check(32'(in_ack), 32'h2, "R4 take sets ack");
        // R8: condition unmet (dock 1 acked) even with all tokens.
        in_data = mk_data(3'b111); cycle();
        check(32'(in_ack), 32'h2, "R8 acked dock blocks joint rule");
        in_req = '0; in_data = '0; cycle();

        // R9: output dock handshake.
        unit_out_send = 2'b01; unit_out_word = 16'hA55A; cycle();
        unit_out_send = '0;
        check(32'(out_req), 32'h1, "R9 send raises request");
        cycle();
        check(32'(out_req), 32'h1, "R9 request holds without ack");
        out_ack = 2'b01; cycle(); out_ack = '0;
        check(32'(out_req), 32'h0, "R9 ack clears request");

        // Random phase; sparse take keeps joint-rule cycles reachable.
        for (int n = 0; n < 3000; n++) begin
            in_req = 3'($urandom_range(0, 7));
            if ($urandom_range(0, 3) == 0) in_req = '1;
            tk = 3'($urandom_range(0, 7));
            for (int i = 0; i < N_IN; i++) begin
                in_data[i*SLICE_W +: WORD_W] = WORD_W'($urandom);
                in_data[i*SLICE_W + WORD_W] = tk[i];
            end
            unit_take = ($urandom_range(0, 3) == 0) ? 3'($urandom_range(0, 7)) : '0;
            unit_out_send = 2'($urandom_range(0, 3));
            unit_out_word = 16'($urandom);
            out_ack = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 199) == 0) rst_n = 1'b0; else rst_n = 1'b1;
            cycle();
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule